// File: doc/BRIEF.md
# Indirect Host Register Access Bridge

This bridge lets a host bus reach a wide internal configuration space through three directly addressed words: a shared data word, a control word and a status word. They sit at offsets 13, 14 and 15 above a base address that is supplied on an input port. Software puts the write data in the data word first. It then writes the control word with an internal address and a direction flag, and that control write launches exactly one internal transaction.

The internal side is a level request that stays high until the target acknowledges it. The target can take any number of cycles. When the acknowledge arrives, a ready bit in the status word sets, and software polls for that bit. The bridge sorts each transaction into one of three kinds, and each kind has its own ready bit: address-filter writes, other configuration writes, and reads. Data returned by a read lands in the data word. A control write that arrives while a transaction is still pending is dropped and raises a sticky error flag. Internal bit 10 selects the second MAC instance, so that instance's addresses are the first instance's plus 0x400.

Top module: `hreg_bridge`

## Requirements
- R1: Host reads decode the host address against the base input: base+13 returns the data word, base+14 returns the last accepted command (address in bits 10:0, bit 15 set for a write, bit 16 set for a read, zero before any command), base+15 returns the status word, and any other address returns zero. A host write to base+13 loads the data word.
- R2: A control write with bit 15 set raises `int_req_o` on the following cycle. The bridge then drives `int_we_o` high, `int_addr_o` equal to control bits 10:0, and `int_wdata_o` equal to the data word as it stood when the control write was taken.
- R3: A control write with bit 16 set and bit 15 clear launches a read, with `int_we_o` low. When both bits are set, the write wins. A control write with neither bit set launches nothing.
- R4: Once raised, `int_req_o` stays high, with address, direction and write data unchanged, until `int_ack_i` is sampled high. It drops on the next cycle.
- R5: Status bit 12 is the ready bit for writes to the address-filter region (internal address bits 9:7 equal to 111, for either value of bit 10). Status bit 0 is the ready bit for all other writes. Status bit 1 is the ready bit for reads.
- R6: A ready bit clears when a transaction of its own kind is accepted. It sets on the cycle after that transaction's acknowledge. The ready bits of the other kinds do not change.
- R7: When a read completes, the data word takes `int_rdata_i` on the same cycle that status bit 1 sets. This load wins over a host data write made in the same cycle.
- R8: A control write taken while a transaction is outstanding is ignored, and it sets status bit 31. Bit 31 stays set until the host writes the status word with bit 31 high.
- R9: An acknowledge that arrives while nothing is outstanding changes neither the status word nor the data word.
- R10: After reset, the request, direction, address, write data, data word and status word are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_i | input | HADDR_W | Base address of the three host words |
| host_wr_i | input | 1 | Host write strobe |
| host_addr_i | input | HADDR_W | Host address, for both reads and writes |
| host_wdata_i | input | DATA_W | Host write data |
| host_rdata_o | output | DATA_W | Host read data for `host_addr_i` (combinational) |
| int_req_o | output | 1 | Internal request, held until acknowledged |
| int_we_o | output | 1 | Internal direction, high for a write |
| int_addr_o | output | IADDR_W | Internal register address |
| int_wdata_o | output | DATA_W | Internal write data |
| int_ack_i | input | 1 | Internal acknowledge |
| int_rdata_i | input | DATA_W | Internal read data, valid with the acknowledge |

## Verification
The bench targets the cycle where the host and the bridge race each other. It sends a second control write while a request is outstanding. A bridge that accepted it would overwrite the pending address and clear the wrong ready bit, and one that dropped it silently would leave the error flag low. The bench also makes a read complete on the same cycle as a host data write, which exposes a bridge that gives priority to the host data. It sends an acknowledge when nothing is pending, which catches a bridge that sets a ready bit or loads the data word without checking for an outstanding request. Finally it sends addresses that differ only in the instance bit, to catch classification logic that looks at bit 10 and so sends an address-filter write to the wrong ready bit.

// File: rtl/hreg_pkg.sv
package hreg_pkg;
  // word offsets above the base
  localparam int unsigned OFS_DATA = 13;
  localparam int unsigned OFS_CTRL = 14;
  localparam int unsigned OFS_STAT = 15;
  // control flags, status error flag (DATA_W must be >= 32)
  localparam int unsigned CTRL_WE  = 15;
  localparam int unsigned CTRL_RD  = 16;
  localparam int unsigned STAT_ERR = 31;
  // address-filter region: addr[9:7] == 3'b111
  localparam int unsigned AF_LSB   = 7;
  localparam logic [2:0]  AF_TAG   = 3'b111;
  localparam int unsigned NUM_KIND = 3;

  typedef enum logic [1:0] {
    K_CFG_WR = 2'd0,
    K_RD     = 2'd1,
    K_AF_WR  = 2'd2
  } kind_e;

  function automatic int unsigned rdy_pos(int unsigned k);
    case (k)
      0:       return 0;
      1:       return 1;
      default: return 12;
    endcase
  endfunction

  function automatic kind_e classify(logic we, logic [2:0] region);
    if (!we)                 return K_RD;
    else if (region == AF_TAG) return K_AF_WR;
    else                     return K_CFG_WR;
  endfunction
endpackage

// File: rtl/hreg_decode.sv
module hreg_decode
  import hreg_pkg::*;
#(
  parameter int unsigned HADDR_W = 10
) (
  input  logic [HADDR_W-1:0] base_i,
  input  logic [HADDR_W-1:0] addr_i,
  input  logic               wr_i,
  output logic               sel_data_o,
  output logic               sel_ctrl_o,
  output logic               sel_stat_o,
  output logic               wr_data_o,
  output logic               wr_ctrl_o,
  output logic               wr_stat_o
);
  logic [HADDR_W-1:0] a_data, a_ctrl, a_stat;

  assign a_data = base_i + HADDR_W'(OFS_DATA);
  assign a_ctrl = base_i + HADDR_W'(OFS_CTRL);
  assign a_stat = base_i + HADDR_W'(OFS_STAT);

  assign sel_data_o = (addr_i == a_data);
  assign sel_ctrl_o = (addr_i == a_ctrl);
  assign sel_stat_o = (addr_i == a_stat);

  assign wr_data_o = wr_i & sel_data_o;
  assign wr_ctrl_o = wr_i & sel_ctrl_o;
  assign wr_stat_o = wr_i & sel_stat_o;
endmodule

// File: rtl/hreg_txn.sv
module hreg_txn
  import hreg_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned IADDR_W = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               launch_i,
  input  logic [DATA_W-1:0]  ctrl_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic               ack_i,
  output logic               req_o,
  output logic               we_o,
  output logic [IADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0]  wdata_o,
  output logic               start_o,
  output kind_e              start_kind_o,
  output logic               done_o,
  output kind_e              done_kind_o,
  output logic               collide_o
);
  logic  want_wr, want_rd, valid_cmd;
  kind_e kind_q;

  assign want_wr   = ctrl_i[CTRL_WE];
  assign want_rd   = ctrl_i[CTRL_RD];
  assign valid_cmd = want_wr | want_rd;

  assign start_o      = launch_i & valid_cmd & ~req_o;
  assign collide_o    = launch_i & req_o;
  assign done_o       = req_o & ack_i;
  assign start_kind_o = classify(want_wr, ctrl_i[AF_LSB+2:AF_LSB]);
  assign done_kind_o  = kind_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o   <= 1'b0;
      we_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
      kind_q  <= K_CFG_WR;
    end else if (start_o) begin
      req_o   <= 1'b1;
      we_o    <= want_wr;
      addr_o  <= ctrl_i[IADDR_W-1:0];
      wdata_o <= data_i;
      kind_q  <= start_kind_o;
    end else if (done_o) begin
      req_o   <= 1'b0;
    end
  end
endmodule

// File: rtl/hreg_status.sv
module hreg_status
  import hreg_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  kind_e               start_kind_i,
  input  logic                done_i,
  input  kind_e               done_kind_i,
  input  logic                collide_i,
  input  logic                clr_err_i,
  output logic [NUM_KIND-1:0] rdy_o,
  output logic                err_o,
  output logic [DATA_W-1:0]   word_o
);
  for (genvar k = 0; k < NUM_KIND; k++) begin : g_rdy
    logic r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                        r_q <= 1'b0;
      else if (start_i && start_kind_i == kind_e'(2'(k))) r_q <= 1'b0;
      else if (done_i && done_kind_i == kind_e'(2'(k)))   r_q <= 1'b1;
    end
    assign rdy_o[k] = r_q;
  end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_o <= 1'b0;
    else if (collide_i) err_o <= 1'b1;
    else if (clr_err_i) err_o <= 1'b0;
  end

  always_comb begin
    word_o = '0;
    for (int unsigned k = 0; k < NUM_KIND; k++) word_o[rdy_pos(k)] = rdy_o[k];
    word_o[STAT_ERR] = err_o;
  end
endmodule

// File: rtl/hreg_bridge.sv
module hreg_bridge
  import hreg_pkg::*;
#(
  parameter int unsigned HADDR_W = 10,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned IADDR_W = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [HADDR_W-1:0] base_i,
  input  logic               host_wr_i,
  input  logic [HADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0]  host_wdata_i,
  output logic [DATA_W-1:0]  host_rdata_o,
  output logic               int_req_o,
  output logic               int_we_o,
  output logic [IADDR_W-1:0] int_addr_o,
  output logic [DATA_W-1:0]  int_wdata_o,
  input  logic               int_ack_i,
  input  logic [DATA_W-1:0]  int_rdata_i
);
  logic sel_data, sel_ctrl, sel_stat, wr_data, wr_ctrl, wr_stat;
  logic start, done, collide, err_q, has_cmd_q;
  kind_e start_kind, done_kind;
  logic [NUM_KIND-1:0] rdy;
  logic [DATA_W-1:0] data_q, stat_word, ctrl_word;

  hreg_decode #(.HADDR_W(HADDR_W)) u_dec (
    .base_i    (base_i),
    .addr_i    (host_addr_i),
    .wr_i      (host_wr_i),
    .sel_data_o(sel_data),
    .sel_ctrl_o(sel_ctrl),
    .sel_stat_o(sel_stat),
    .wr_data_o (wr_data),
    .wr_ctrl_o (wr_ctrl),
    .wr_stat_o (wr_stat)
  );

  hreg_txn #(.DATA_W(DATA_W), .IADDR_W(IADDR_W)) u_txn (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .launch_i    (wr_ctrl),
    .ctrl_i      (host_wdata_i),
    .data_i      (data_q),
    .ack_i       (int_ack_i),
    .req_o       (int_req_o),
    .we_o        (int_we_o),
    .addr_o      (int_addr_o),
    .wdata_o     (int_wdata_o),
    .start_o     (start),
    .start_kind_o(start_kind),
    .done_o      (done),
    .done_kind_o (done_kind),
    .collide_o   (collide)
  );

  hreg_status #(.DATA_W(DATA_W)) u_stat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .start_kind_i(start_kind),
    .done_i      (done),
    .done_kind_i (done_kind),
    .collide_i   (collide),
    .clr_err_i   (wr_stat & host_wdata_i[STAT_ERR]),
    .rdy_o       (rdy),
    .err_o       (err_q),
    .word_o      (stat_word)
  );

  // read completion has priority over host data write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                data_q <= '0;
    else if (done && !int_we_o) data_q <= int_rdata_i;
    else if (wr_data)           data_q <= host_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    has_cmd_q <= 1'b0;
    else if (start) has_cmd_q <= 1'b1;
  end

  always_comb begin
    ctrl_word                = '0;
    ctrl_word[IADDR_W-1:0]   = int_addr_o;
    ctrl_word[CTRL_WE]       = has_cmd_q & int_we_o;
    ctrl_word[CTRL_RD]       = has_cmd_q & ~int_we_o;
  end

  always_comb begin
    if (sel_data)      host_rdata_o = data_q;
    else if (sel_ctrl) host_rdata_o = ctrl_word;
    else if (sel_stat) host_rdata_o = stat_word;
    else               host_rdata_o = '0;
  end
endmodule

// File: rtl/hreg_bridge_chk.sv
module hreg_bridge_chk
  import hreg_pkg::*;
#(
  parameter int unsigned HADDR_W = 10,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned IADDR_W = 11
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [HADDR_W-1:0]  base_i,
  input logic                host_wr_i,
  input logic [HADDR_W-1:0]  host_addr_i,
  input logic [DATA_W-1:0]   host_wdata_i,
  input logic                int_req_o,
  input logic                int_we_o,
  input logic [IADDR_W-1:0]  int_addr_o,
  input logic [DATA_W-1:0]   int_wdata_o,
  input logic                int_ack_i,
  input logic [DATA_W-1:0]   int_rdata_i,
  input logic [DATA_W-1:0]   data_q,
  input logic [NUM_KIND-1:0] rdy,
  input logic                err_q
);
  logic err_clr;
  assign err_clr = host_wr_i && host_wdata_i[STAT_ERR] &&
                   (host_addr_i == base_i + HADDR_W'(OFS_STAT));

  p_req_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_req_o && !int_ack_i |=> int_req_o && $stable(int_addr_o) &&
                                $stable(int_we_o) && $stable(int_wdata_o));

  p_req_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_req_o && int_ack_i |=> !int_req_o);

  p_af_rdy_on_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy[K_AF_WR]) |-> $past(int_req_o && int_ack_i && int_we_o));

  p_rd_rdy_on_ack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy[K_RD]) |-> $past(int_req_o && int_ack_i && !int_we_o));

  p_rd_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_req_o && int_ack_i && !int_we_o |=> data_q == $past(int_rdata_i) && rdy[K_RD]);

  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q && !err_clr |=> err_q);

  p_stray_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_req_o && int_ack_i && !host_wr_i |=> $stable(rdy) && $stable(data_q));
endmodule

bind hreg_bridge hreg_bridge_chk #(
  .HADDR_W(HADDR_W), .DATA_W(DATA_W), .IADDR_W(IADDR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .base_i      (base_i),
  .host_wr_i   (host_wr_i),
  .host_addr_i (host_addr_i),
  .host_wdata_i(host_wdata_i),
  .int_req_o   (int_req_o),
  .int_we_o    (int_we_o),
  .int_addr_o  (int_addr_o),
  .int_wdata_o (int_wdata_o),
  .int_ack_i   (int_ack_i),
  .int_rdata_i (int_rdata_i),
  .data_q      (data_q),
  .rdy         (rdy),
  .err_q       (err_q)
);

// File: tb/sim_hreg_bridge.sv
`timescale 1ns/1ps
module sim_hreg_bridge;
  localparam int HW = 10;
  localparam int DW = 32;
  localparam int AW = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [HW-1:0] base = 10'h040;
  logic host_wr = 1'b0;
  logic [HW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] host_rdata;
  logic int_req, int_we, int_ack = 1'b0;
  logic [AW-1:0] int_addr;
  logic [DW-1:0] int_wdata, int_rdata = '0;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  hreg_bridge #(.HADDR_W(HW), .DATA_W(DW), .IADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .base_i(base),
    .host_wr_i(host_wr), .host_addr_i(host_addr), .host_wdata_i(host_wdata),
    .host_rdata_o(host_rdata),
    .int_req_o(int_req), .int_we_o(int_we), .int_addr_o(int_addr),
    .int_wdata_o(int_wdata), .int_ack_i(int_ack), .int_rdata_i(int_rdata)
  );

  typedef struct packed {
    logic [31:0] ctrl;
    logic [31:0] wdat;
    logic [3:0]  wait_n;
    logic [31:0] rdat;
    logic [31:0] stat;
    logic [31:0] mask;
  } vec_t;

  // status after completion; mask = ready bit of this kind
  localparam vec_t VEC [7] = '{
    '{32'h0000_8788, 32'hDEAF_CAFE, 4'd2, 32'h0,         32'h1000, 32'h1000},
    '{32'h0000_878C, 32'h0081_FACE, 4'd0, 32'h0,         32'h1000, 32'h1000},
    '{32'h0000_8340, 32'h0000_000A, 4'd3, 32'h0,         32'h1001, 32'h0001},
    '{32'h0001_03B0, 32'h0000_0100, 4'd1, 32'h0000_1234, 32'h1003, 32'h0002},
    '{32'h0000_8388, 32'h1111_2222, 4'd4, 32'h0,         32'h1003, 32'h1000},
    '{32'h0001_0240, 32'h0,         4'd0, 32'hBEEF_5A5A, 32'h1003, 32'h0002},
    '{32'h0001_8390, 32'h3333_4444, 4'd1, 32'h0,         32'h1003, 32'h1000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int ofs, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = base + HW'(ofs); host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input int ofs, output logic [31:0] v);
    host_addr = base + HW'(ofs);
    #1 v = host_rdata;
  endtask

  task automatic ack(input logic [31:0] d);
    @(negedge clk);
    int_ack = 1'b1; int_rdata = d;
    @(negedge clk);
    int_ack = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 req", {31'b0, int_req}, 32'h0);
    chk("R10 addr", {21'b0, int_addr}, 32'h0);
    chk("R10 wdata", int_wdata, 32'h0);
    rd(15, v); chk("R10 status", v, 32'h0);
    rd(13, v); chk("R10 data", v, 32'h0);
    rd(14, v); chk("R1 ctrl before cmd", v, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < 7; i++) begin
      logic we;
      we = VEC[i].ctrl[15];
      wr(13, VEC[i].wdat);
      wr(14, VEC[i].ctrl);
      chk("R2/R3 req up", {31'b0, int_req}, 32'h1);
      chk("R2/R3 dir", {31'b0, int_we}, {31'b0, we});
      chk("R2 addr", {21'b0, int_addr}, {21'b0, VEC[i].ctrl[10:0]});
      if (we) chk("R2 wdata", int_wdata, VEC[i].wdat);
      rd(15, v); chk("R6 ready cleared", v, VEC[i].stat & ~VEC[i].mask);
      rd(14, v); chk("R1 ctrl readback", v,
                     {15'b0, ~we, we, 4'b0, VEC[i].ctrl[10:0]});
      for (int w = 0; w < int'(VEC[i].wait_n); w++) begin
        @(negedge clk);
        chk("R4 req held", {31'b0, int_req}, 32'h1);
        chk("R4 addr held", {21'b0, int_addr}, {21'b0, VEC[i].ctrl[10:0]});
      end
      ack(VEC[i].rdat);
      chk("R4 req drop", {31'b0, int_req}, 32'h0);
      rd(15, v); chk("R5/R6 ready set", v, VEC[i].stat);
      rd(13, v); chk("R7/R1 data word", v, we ? VEC[i].wdat : VEC[i].rdat);
    end

    // R3 no flag: nothing launched
    wr(14, 32'h0000_0388);
    chk("R3 no flag no req", {31'b0, int_req}, 32'h0);
    rd(15, v); chk("R3 no flag status", v, 32'h1003);

    // R8 collision
    wr(14, 32'h0000_8010);
    rd(15, v); chk("R6 cfg ready cleared", v, 32'h1002);
    wr(14, 32'h0000_8390);
    chk("R8 req kept", {31'b0, int_req}, 32'h1);
    chk("R8 addr kept", {21'b0, int_addr}, 32'h010);
    rd(15, v); chk("R8 err set", v, 32'h8000_1002);
    ack(32'h0);
    rd(15, v); chk("R8 af ready untouched", v, 32'h8000_1003);
    wr(15, 32'h0000_0000);
    rd(15, v); chk("R8 err sticky", v, 32'h8000_1003);
    wr(15, 32'h8000_0000);
    rd(15, v); chk("R8 err cleared", v, 32'h1003);

    // R9 stray ack
    ack(32'hFFFF_FFFF);
    chk("R9 no req", {31'b0, int_req}, 32'h0);
    rd(15, v); chk("R9 status", v, 32'h1003);
    rd(13, v); chk("R9 data", v, 32'h3333_4444);

    // R7 race: completion vs host data write
    wr(14, 32'h0001_0001);
    @(negedge clk);
    int_ack = 1'b1; int_rdata = 32'hA5A5_0F0F;
    host_wr = 1'b1; host_addr = base + HW'(13); host_wdata = 32'h5555_5555;
    @(negedge clk);
    int_ack = 1'b0; host_wr = 1'b0;
    rd(13, v); chk("R7 read wins", v, 32'hA5A5_0F0F);

    // R1 unmapped and base move
    rd(12, v); chk("R1 unmapped", v, 32'h0);
    base = 10'h100;
    rd(15, v); chk("R1 moved base", v, 32'h1003);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule